// File: doc/BRIEF.md
# Vector Loop Step and Query Unit

This block owns the loop position of a vector engine: a source element index, a destination element index, a source sub-element index and a destination sub-element index. It also owns two order flags that make the sub-element loop the outer loop. Each accepted request carries a 4-bit mode code, a step-enable bit and a record bit. Depending on the mode, a request does one of four things:

- reads back one of the four loop counters;
- reads back one of four schedule offsets, which are supplied on an input port;
- rewrites the two order flags;
- advances the source and destination walkers by one element.

The vector length and the sub-vector length arrive as configuration inputs. Per-element predicate masks and skip enables also arrive as inputs. A walker with skip enabled jumps over masked-out elements.

The result is registered and appears one cycle after the request, zero-extended to the result width. When the record bit is set, a 4-bit condition field comes with it. Its EQ bit flags that the request was made on the final element of either walk. The step-enable bit decides whether a request may change the loop state at all. A pure query can therefore be issued without disturbing an iteration in progress.

Top module: `vstep_unit`

## Requirements
- R1: After synchronous reset, all four counters and both order flags are zero, and `res_valid`, `res_cr_valid`, `res_data` and `res_cr` are zero.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. With no request, it stays low.
- R3: Modes 5, 6, 7 and 8 return, zero-extended and taken before the request acts, the source index, destination index, source sub-index and destination sub-index respectively.
- R4: Modes 1 to 4 return schedule offset 0 to 3, zero-extended. Offset k sits at `shape_off[k*7 +: 7]`.
- R5: Modes 12 to 15 return `{mode[0], mode[1]}` zero-extended. Bit 1 of that result is the source order flag and bit 0 is the destination order flag. With step-enable set, the source flag takes `mode[0]` and the destination flag takes `mode[1]`.
- R6: Mode 0 returns zero. With step-enable set, it advances the source walker and the destination walker once each, in the same cycle.
- R7: A walker whose order flag is 0 steps its sub-index first. Below `cfg_subvl` the sub-index increments. At `cfg_subvl` the sub-index returns to 0 and the element index moves to the next element, wrapping to 0 after the last one.
- R8: A walker whose order flag is 1 steps its element index first. After the last element, the element index returns to 0 and the sub-index increments, or wraps to 0 when it was equal to `cfg_subvl`.
- R9: With its skip bit set, a walker's next element is the lowest index above the current one and below `cfg_vl` whose mask bit is 1. When no such index exists, the walker behaves as at the last element. A wrap always lands on index 0, whatever its mask bit.
- R10: With step-enable clear, no mode changes the counters or the order flags.
- R11: Modes 9, 10 and 11 return zero and leave the state unchanged.
- R12: With the record bit set, `res_cr_valid` rises with `res_valid`, and `res_cr` is {LT, GT, EQ, SO} with bits 3 to 0. EQ is bit 1 and is 1 when, before the request, the source index is `cfg_vl-1` with sub-index `cfg_subvl`, or the destination index is `cfg_vl-1` with sub-index `cfg_subvl`. The other bits are 0. With the record bit clear, `res_cr_valid` and `res_cr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Mode code |
| req_step_en | input | 1 | Allows the request to change loop state |
| req_record | input | 1 | Requests the condition field |
| cfg_vl | input | 7 | Vector length, 1 to 64 |
| cfg_subvl | input | 2 | Sub-vector length minus one |
| src_mask | input | 64 | Source element predicate |
| dst_mask | input | 64 | Destination element predicate |
| src_skip | input | 1 | Source walker skips masked-out elements |
| dst_skip | input | 1 | Destination walker skips masked-out elements |
| shape_off | input | 28 | Four 7-bit schedule offsets |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_data | output | DATA_W | Zero-extended result |
| res_cr_valid | output | 1 | Condition field is written |
| res_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The end-of-loop report and the advance coincide when a step request with the record bit set lands on the final element. The EQ bit must describe the position before the step, while the state wraps at the same clock edge. This case is provoked in a directed run that walks a skipping source walker to its last unmasked element. It is also provoked many times by random steps with short vector lengths and random record bits. Each result is judged against a bench model that evaluates the end condition before it applies the advance.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int unsigned VS_STEP_W = 7;
    localparam int unsigned VS_SUB_W  = 2;
    localparam int unsigned VS_MAX_VL = 2 ** (VS_STEP_W - 1);
    localparam int unsigned VS_SHAPES = 4;

    typedef enum logic [2:0] {
        OP_ADVANCE,
        OP_SHAPE,
        OP_COUNTER,
        OP_ORDER,
        OP_NONE
    } vs_op_e;

    typedef struct packed {
        logic [VS_STEP_W-1:0] src_step;
        logic [VS_STEP_W-1:0] dst_step;
        logic [VS_SUB_W-1:0]  src_sub;
        logic [VS_SUB_W-1:0]  dst_sub;
        logic                 src_outer;
        logic                 dst_outer;
    } vs_state_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } vs_cr_t;

    function automatic vs_op_e vs_decode(input logic [3:0] mode);
        if (mode == 4'd0)             return OP_ADVANCE;
        else if (mode <= 4'd4)        return OP_SHAPE;
        else if (mode <= 4'd8)        return OP_COUNTER;
        else if (mode[3:2] == 2'b11)  return OP_ORDER;
        else                          return OP_NONE;
    endfunction

    function automatic logic vs_at_end(input vs_state_t s,
                                       input logic [VS_STEP_W-1:0] vl,
                                       input logic [VS_SUB_W-1:0] subvl);
        logic [VS_STEP_W-1:0] last;
        last = vl - VS_STEP_W'(1);
        return ((s.src_step == last) && (s.src_sub == subvl)) ||
               ((s.dst_step == last) && (s.dst_sub == subvl));
    endfunction

endpackage

// File: rtl/vstep_seek.sv
module vstep_seek #(
    parameter int unsigned N = 64,
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] vl,
    input  logic [N-1:0] mask,
    input  logic         skip,
    output logic         found,
    output logic [W-1:0] nxt
);
    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if ((i > int'(cur)) && (i < int'(vl)) && (!skip || mask[i])) begin
                found = 1'b1;
                nxt   = W'(i);
            end
        end
    end
endmodule

// File: rtl/vstep_walker.sv
module vstep_walker #(
    parameter int unsigned N  = 64,
    parameter int unsigned W  = 7,
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  cur_step,
    input  logic [SW-1:0] cur_sub,
    input  logic          outer_sub,
    input  logic [W-1:0]  vl,
    input  logic [SW-1:0] subvl,
    input  logic [N-1:0]  mask,
    input  logic          skip,
    output logic [W-1:0]  nxt_step,
    output logic [SW-1:0] nxt_sub
);
    logic         hit;
    logic [W-1:0] hit_idx;
    logic         sub_last;

    vstep_seek #(.N(N), .W(W)) u_seek (
        .cur   (cur_step),
        .vl    (vl),
        .mask  (mask),
        .skip  (skip),
        .found (hit),
        .nxt   (hit_idx)
    );

    assign sub_last = (cur_sub == subvl);

    always_comb begin
        nxt_step = cur_step;
        nxt_sub  = cur_sub;
        if (!outer_sub) begin
            if (!sub_last) begin
                nxt_sub = cur_sub + SW'(1);
            end else begin
                nxt_sub  = '0;
                nxt_step = hit ? hit_idx : '0;
            end
        end else begin
            if (hit) begin
                nxt_step = hit_idx;
            end else begin
                nxt_step = '0;
                nxt_sub  = sub_last ? '0 : cur_sub + SW'(1);
            end
        end
    end

    // R9
    skip_lands_on_set_chk: assert property (@(posedge clk) disable iff (rst)
        (skip && hit) |-> mask[hit_idx]);

    // R9
    skip_moves_forward_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_idx > cur_step) && (hit_idx < vl));

endmodule

// File: rtl/vstep_unit.sv
module vstep_unit
    import vstep_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic [3:0]                     req_mode,
    input  logic                           req_step_en,
    input  logic                           req_record,
    input  logic [VS_STEP_W-1:0]           cfg_vl,
    input  logic [VS_SUB_W-1:0]            cfg_subvl,
    input  logic [VS_MAX_VL-1:0]           src_mask,
    input  logic [VS_MAX_VL-1:0]           dst_mask,
    input  logic                           src_skip,
    input  logic                           dst_skip,
    input  logic [VS_SHAPES*VS_STEP_W-1:0] shape_off,
    output logic                           res_valid,
    output logic [DATA_W-1:0]              res_data,
    output logic                           res_cr_valid,
    output logic [3:0]                     res_cr
);
    localparam int unsigned SIDES = 2;

    vs_state_t                st, st_next;
    vs_op_e                   op;
    logic [DATA_W-1:0]        result_c;
    vs_cr_t                   cr_c;
    logic [1:0]               shape_sel;
    logic [1:0]               ctr_sel;

    logic [VS_STEP_W-1:0]     w_step [SIDES];
    logic [VS_SUB_W-1:0]      w_sub  [SIDES];
    logic                     w_out  [SIDES];
    logic [VS_MAX_VL-1:0]     w_mask [SIDES];
    logic                     w_skip [SIDES];
    logic [VS_STEP_W-1:0]     n_step [SIDES];
    logic [VS_SUB_W-1:0]      n_sub  [SIDES];

    assign op        = vs_decode(req_mode);
    assign shape_sel = 2'(req_mode - 4'd1);
    assign ctr_sel   = 2'(req_mode - 4'd5);

    always_comb begin
        w_step[0] = st.src_step;  w_step[1] = st.dst_step;
        w_sub[0]  = st.src_sub;   w_sub[1]  = st.dst_sub;
        w_out[0]  = st.src_outer; w_out[1]  = st.dst_outer;
        w_mask[0] = src_mask;     w_mask[1] = dst_mask;
        w_skip[0] = src_skip;     w_skip[1] = dst_skip;
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        vstep_walker #(
            .N  (VS_MAX_VL),
            .W  (VS_STEP_W),
            .SW (VS_SUB_W)
        ) u_walk (
            .clk       (clk),
            .rst       (rst),
            .cur_step  (w_step[g]),
            .cur_sub   (w_sub[g]),
            .outer_sub (w_out[g]),
            .vl        (cfg_vl),
            .subvl     (cfg_subvl),
            .mask      (w_mask[g]),
            .skip      (w_skip[g]),
            .nxt_step  (n_step[g]),
            .nxt_sub   (n_sub[g])
        );
    end

    always_comb begin
        st_next = st;
        if (req_step_en) begin
            unique case (op)
                OP_ADVANCE: begin
                    st_next.src_step = n_step[0];
                    st_next.src_sub  = n_sub[0];
                    st_next.dst_step = n_step[1];
                    st_next.dst_sub  = n_sub[1];
                end
                OP_ORDER: begin
                    st_next.src_outer = req_mode[0];
                    st_next.dst_outer = req_mode[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        result_c = '0;
        unique case (op)
            OP_SHAPE:   result_c = DATA_W'(shape_off[shape_sel*VS_STEP_W +: VS_STEP_W]);
            OP_COUNTER: begin
                unique case (ctr_sel)
                    2'd0:    result_c = DATA_W'(st.src_step);
                    2'd1:    result_c = DATA_W'(st.dst_step);
                    2'd2:    result_c = DATA_W'(st.src_sub);
                    default: result_c = DATA_W'(st.dst_sub);
                endcase
            end
            OP_ORDER:   result_c = DATA_W'({req_mode[0], req_mode[1]});
            default:    result_c = '0;
        endcase
    end

    always_comb begin
        cr_c    = '0;
        cr_c.eq = vs_at_end(st, cfg_vl, cfg_subvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= '0;
            res_valid    <= 1'b0;
            res_data     <= '0;
            res_cr_valid <= 1'b0;
            res_cr       <= '0;
        end else begin
            res_valid    <= req_valid;
            res_cr_valid <= req_valid && req_record;
            if (req_valid) begin
                st       <= st_next;
                res_data <= result_c;
                res_cr   <= req_record ? cr_c : '0;
            end
        end
    end

    // R2
    result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    // R2
    idle_is_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid && !res_cr_valid);

    // R10
    no_enable_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_step_en) |=> (st == $past(st)));

    // R11
    reserved_mode_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode >= 4'd9 && req_mode <= 4'd11)
        |=> (res_data == '0) && (st == $past(st)));

    // R5
    order_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_step_en && req_mode[3:2] == 2'b11)
        |=> (st.src_outer == $past(req_mode[0])) && (st.dst_outer == $past(req_mode[1])));

    // R12
    cr_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_cr_valid |-> res_valid);

endmodule

// File: tb/tb_vstep_unit.sv
`timescale 1ns/1ps
module tb_vstep_unit;
    localparam int DW = 64;
    localparam int W  = 7;
    localparam int N  = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic [3:0]      req_mode;
    logic            req_step_en;
    logic            req_record;
    logic [W-1:0]    cfg_vl;
    logic [1:0]      cfg_subvl;
    logic [N-1:0]    src_mask, dst_mask;
    logic            src_skip, dst_skip;
    logic [4*W-1:0]  shape_off;
    logic            res_valid;
    logic [DW-1:0]   res_data;
    logic            res_cr_valid;
    logic [3:0]      res_cr;

    always #10 clk = ~clk;

    vstep_unit #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_step_en(req_step_en), .req_record(req_record), .cfg_vl(cfg_vl),
        .cfg_subvl(cfg_subvl), .src_mask(src_mask), .dst_mask(dst_mask),
        .src_skip(src_skip), .dst_skip(dst_skip), .shape_off(shape_off),
        .res_valid(res_valid), .res_data(res_data),
        .res_cr_valid(res_cr_valid), .res_cr(res_cr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int m_ss, m_ds, m_su, m_du, vl_m, sub_m;
    bit m_pk, m_up;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int next_el(int cur, logic [N-1:0] m, bit sk);
        for (int i = cur + 1; i < vl_m; i++)
            if (!sk || m[i]) return i;
        return -1;
    endfunction

    task automatic walk(inout int el, inout int sb, input bit outer,
                        input logic [N-1:0] m, input bit sk);
        int n;
        n = next_el(el, m, sk);
        if (!outer) begin
            if (sb != sub_m) sb = sb + 1;
            else begin sb = 0; el = (n < 0) ? 0 : n; end
        end else begin
            if (n >= 0) el = n;
            else begin el = 0; sb = (sb == sub_m) ? 0 : sb + 1; end
        end
    endtask

    function automatic string tag_of(logic [3:0] mode, bit en);
        if (mode == 0)       return en ? "R6" : "R10";
        else if (mode <= 4)  return "R4";
        else if (mode <= 8)  return "R3";
        else if (mode <= 11) return "R11";
        else                 return "R5";
    endfunction

    task automatic req(input logic [3:0] mode, input bit en, input bit rec, input string tag);
        logic [63:0] e;
        bit eq;
        case (mode)
            4'd1, 4'd2, 4'd3, 4'd4: e = 64'(shape_off[(int'(mode) - 1) * W +: W]);
            4'd5: e = 64'(m_ss);
            4'd6: e = 64'(m_ds);
            4'd7: e = 64'(m_su);
            4'd8: e = 64'(m_du);
            4'd12, 4'd13, 4'd14, 4'd15: e = 64'({mode[0], mode[1]});
            default: e = 64'd0;
        endcase
        eq = ((m_ss == vl_m - 1) && (m_su == sub_m)) || ((m_ds == vl_m - 1) && (m_du == sub_m));
        req_valid = 1'b1; req_mode = mode; req_step_en = en; req_record = rec;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 64'(res_valid), 64'd1);
        chk({tag, " data"}, res_data, e);
        chk({"R12 cr_valid ", tag}, 64'(res_cr_valid), 64'(rec));
        chk({"R12 cr ", tag}, 64'(res_cr), (rec && eq) ? 64'd2 : 64'd0);
        if (en) begin
            if (mode == 0) begin
                walk(m_ss, m_su, m_pk, src_mask, src_skip);
                walk(m_ds, m_du, m_up, dst_mask, dst_skip);
            end else if (mode[3:2] == 2'b11) begin
                m_pk = mode[0];
                m_up = mode[1];
            end
        end
    endtask

    task automatic restart(input int vl, input int subvl);
        cfg_vl = W'(vl); cfg_subvl = 2'(subvl);
        vl_m = vl; sub_m = subvl;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ss = 0; m_ds = 0; m_su = 0; m_du = 0; m_pk = 0; m_up = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        req_valid = 0; req_mode = 0; req_step_en = 0; req_record = 0;
        src_mask = '0; dst_mask = '0; src_skip = 0; dst_skip = 0;
        shape_off = {7'd101, 7'd77, 7'd42, 7'd9};
        restart(3, 1);

        // R1 reset state
        chk("R1 res_valid", 64'(res_valid), 64'd0);
        chk("R1 res_cr_valid", 64'(res_cr_valid), 64'd0);
        chk("R1 res_data", res_data, 64'd0);
        for (int k = 5; k <= 8; k++) req(4'(k), 1'b0, 1'b0, "R1");
        // R1 order flags zero: one step moves sub-index first
        req(4'd0, 1'b1, 1'b0, "R6");
        req(4'd7, 1'b0, 1'b0, "R1");
        req(4'd5, 1'b0, 1'b0, "R1");
        // R2 idle cycle
        @(posedge clk); @(negedge clk);
        chk("R2 idle", 64'(res_valid), 64'd0);

        // R4 schedule offsets
        for (int k = 1; k <= 4; k++) req(4'(k), 1'b1, 1'b0, "R4");

        // R5 / R8: source outer, destination inner
        restart(3, 1);
        req(4'd13, 1'b1, 1'b0, "R5");
        for (int s = 0; s < 7; s++) begin
            req(4'd0, 1'b1, 1'b1, "R8");
            req(4'd5, 1'b0, 1'b0, "R8");
            req(4'd7, 1'b0, 1'b0, "R8");
            req(4'd6, 1'b0, 1'b0, "R7");
            req(4'd8, 1'b0, 1'b0, "R7");
        end
        // R10 disabled writes and steps
        req(4'd14, 1'b0, 1'b0, "R10");
        req(4'd0, 1'b0, 1'b0, "R10");
        req(4'd0, 1'b1, 1'b0, "R10");
        req(4'd5, 1'b0, 1'b0, "R10");
        req(4'd8, 1'b0, 1'b0, "R10");
        // R11 reserved
        for (int k = 9; k <= 11; k++) begin
            req(4'(k), 1'b1, 1'b1, "R11");
            req(4'd5, 1'b0, 1'b0, "R11");
        end

        // R9 skip and R12 end-of-loop on the last unmasked element
        restart(8, 0);
        src_mask = 64'b1010_0100; src_skip = 1'b1;
        dst_mask = 64'h0; dst_skip = 1'b0;
        for (int s = 0; s < 5; s++) begin
            req(4'd0, 1'b1, 1'b1, "R12");
            req(4'd5, 1'b0, 1'b0, "R9");
            req(4'd6, 1'b0, 1'b0, "R9");
        end
        // R9 empty mask on destination: every step wraps
        dst_skip = 1'b1;
        for (int s = 0; s < 3; s++) begin
            req(4'd0, 1'b1, 1'b1, "R9");
            req(4'd6, 1'b0, 1'b0, "R9");
        end

        // random phases
        for (int ph = 0; ph < 8; ph++) begin
            restart(1 + int'($urandom_range(9)), int'($urandom_range(3)));
            for (int r = 0; r < 300; r++) begin
                logic [3:0] md;
                bit en;
                md = ($urandom_range(1) == 0) ? 4'd0 : 4'($urandom_range(15));
                en = ($urandom_range(3) != 0);
                src_mask = {$urandom, $urandom};
                dst_mask = {$urandom, $urandom};
                src_skip = 1'($urandom_range(1));
                dst_skip = 1'($urandom_range(1));
                shape_off = 28'($urandom);
                req(md, en, 1'($urandom_range(1)), tag_of(md, en));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule